// File: doc/BRIEF.md
# Two-Way Cache Maintenance Unit

This block holds a small two-way set-associative data-cache array and runs maintenance commands on it directly, one command per clock. A command carries an opcode, two 32-bit operands whose sum is the effective address (the first operand can be forced to zero), the page attributes of that address, and two configuration bits that steer diagnostic reads. The unit can establish a zero-filled, modified line without fetching memory. It can drop both ways of a congruence class, discarding modified data. It can return the raw tag and state, or one data word, of a chosen way. Two touch hints are accepted and treated alike.

The geometry has 16 classes of two ways, each line eight 32-bit words. Address bits [4:2] pick the word, bits [8:5] pick the class, and bits [31:9] form the tag. Each class keeps one replacement bit that names the way to evict next. Every accepted command produces a one-cycle done strobe in the following cycle, together with its result word and exception flag.

Top module: `cache_maint_unit`

## Requirements
- R1: The effective address is operand B plus operand A, or operand B alone when `base_is_zero` is 1. Bits [4:2] select the word, [8:5] the class and [31:9] the tag.
- R2: Zero-line (opcode 3) on a cacheable write-back address writes all eight words of the target line to zero and sets its valid and dirty bits. On a hit the hit way is reused and the other way is left untouched.
- R3: On a zero-line miss an invalid way is filled first (way 0 before way 1) with the new tag. No memory read is involved.
- R4: Each class keeps a replacement bit naming the victim when both ways are valid. A zero-line fill or a touch hit on way w sets it to the other way.
- R5: Zero-line with `attr_cacheable`=0 or `attr_wthru`=1 raises `align_exc` in its done cycle and changes no tag, state, data or replacement bit.
- R6: Class invalidate (opcode 4) clears valid and dirty in both ways of the class. It leaves tags, data words and the replacement bit as they were.
- R7: Diagnostic read (opcode 5) returns from way `cfg_diag_way` of the class, whether or not the address hits. With `cfg_diag_tag`=1 the result is tag in [31:9], zeros in [8:2], valid in bit 1 and dirty in bit 0. With `cfg_diag_tag`=0 it is the data word chosen by address bits [4:2].
- R8: Touch-for-load (opcode 1) and touch-for-store (opcode 2) behave identically. A hit only updates the replacement bit as in R4, and a miss changes nothing.
- R9: `done` is 1 for exactly the cycle after each accepted command. `align_exc` is only ever 1 alongside `done`. `result` is zero after every opcode other than 5. Opcodes 0, 6 and 7 change nothing.
- R10: After reset all ways are invalid and clean, every replacement bit names way 0, and outputs are zero. Data word k of way w in class c holds 0xD0000000 | w<<12 | c<<4 | k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command accepted at this edge |
| cmd_op | input | 3 | Opcode: 1/2 touch, 3 zero-line, 4 class invalidate, 5 diagnostic read |
| base_is_zero | input | 1 | Use zero instead of operand A |
| opnd_a | input | 32 | First address operand |
| opnd_b | input | 32 | Second address operand |
| attr_cacheable | input | 1 | Address is cacheable |
| attr_wthru | input | 1 | Address is write-through |
| cfg_diag_way | input | 1 | Way read by a diagnostic read |
| cfg_diag_tag | input | 1 | Diagnostic read returns tag/state (1) or data word (0) |
| result | output | 32 | Diagnostic result, zero otherwise |
| align_exc | output | 1 | Alignment exception for a refused zero-line |
| done | output | 1 | One-cycle completion strobe |

## Verification
Every result of this block (`done`, `align_exc` and `result`) is registered once. All three are due in the cycle that follows the edge at which the command is accepted. The bench drives a command at a falling edge and lets one rising edge accept it. It compares all three outputs at the next falling edge, then checks that `done` is low one cycle later whenever no command follows. Array effects such as fills, invalidations and replacement choices are never read internally. Each is observed through later diagnostic reads, which follow the same one-cycle rule, so every class, way and word is checked against a model the bench keeps from the requirements.

// File: rtl/cmu_pkg.sv
// Shared definitions for the cache maintenance unit.
// Assumes a fixed two-way organisation and 32-bit data words.
package cmu_pkg;
    localparam int DATA_W = 32;
    localparam int WAYS   = 2;

    typedef enum logic [2:0] {
        OP_NONE     = 3'd0,
        OP_TOUCH_LD = 3'd1,
        OP_TOUCH_ST = 3'd2,
        OP_ZERO     = 3'd3,
        OP_CINV     = 3'd4,
        OP_DREAD    = 3'd5
    } maint_op_e;

    // Power-on content of a data word, so that zero-fill is observable.
    function automatic logic [DATA_W-1:0] seed_word(input int way, input int cls, input int word);
        return 32'hD000_0000 | (32'(way) << 12) | (32'(cls) << 4) | 32'(word);
    endfunction
endpackage

// File: rtl/cmu_agen.sv
// Effective-address generator: adds the two operands (first one optionally
// replaced by zero) and splits the sum into word, class and tag fields.
// Assumes the word select sits just above the two byte-offset bits.
module cmu_agen #(
    parameter int ADDR_W = 32,
    parameter int WSEL_W = 3,
    parameter int IDX_W  = 4,
    localparam int OFF_W = WSEL_W + 2,
    localparam int TAG_W = ADDR_W - OFF_W - IDX_W
) (
    input  logic              base_zero,
    input  logic [ADDR_W-1:0] opnd_a,
    input  logic [ADDR_W-1:0] opnd_b,
    output logic [WSEL_W-1:0] word_sel,
    output logic [IDX_W-1:0]  set_sel,
    output logic [TAG_W-1:0]  tag_val
);
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] ea;

    // Pick the base operand and form the sum.
    always_comb begin
        base = base_zero ? '0 : opnd_a;
        ea   = base + opnd_b;
    end

    assign word_sel = ea[OFF_W-1:2];
    assign set_sel  = ea[OFF_W+IDX_W-1:OFF_W];
    assign tag_val  = ea[ADDR_W-1:OFF_W+IDX_W];
endmodule

// File: rtl/cmu_array.sv
// Tag, state, replacement and data storage for a two-way cache.
// One storage slice per class; only the class addressed by rd_set can be
// written in a cycle. Reads are combinational. Assumes WAYS == 2.
module cmu_array
    import cmu_pkg::*;
#(
    parameter int SETS   = 16,
    parameter int WORDS  = 8,
    parameter int TAG_W  = 23,
    localparam int IDX_W  = $clog2(SETS),
    localparam int WSEL_W = $clog2(WORDS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [IDX_W-1:0]            rd_set,
    input  logic                        rd_way,
    input  logic [WSEL_W-1:0]           rd_word,
    input  logic                        zfill_en,
    input  logic                        zfill_way,
    input  logic [TAG_W-1:0]            zfill_tag,
    input  logic                        cinv_en,
    input  logic                        lru_we,
    input  logic                        lru_nxt,
    output logic [WAYS-1:0][TAG_W-1:0]  set_tag,
    output logic [WAYS-1:0]             set_valid,
    output logic [WAYS-1:0]             set_dirty,
    output logic                        set_lru,
    output logic [DATA_W-1:0]           word_data
);
    logic [WAYS-1:0][TAG_W-1:0] all_tag  [SETS];
    logic [WAYS-1:0]            all_vld  [SETS];
    logic [WAYS-1:0]            all_drt  [SETS];
    logic                       all_lru  [SETS];
    logic [DATA_W-1:0]          all_word [SETS];

    for (genvar s = 0; s < SETS; s++) begin : g_set
        logic [TAG_W-1:0]  tag_q [WAYS];
        logic [WAYS-1:0]   vld_q;
        logic [WAYS-1:0]   drt_q;
        logic              lru_q;
        logic [DATA_W-1:0] dat_q [WAYS][WORDS];
        logic              here;

        assign here = (rd_set == IDX_W'(s));

        // Hold and update the state of one congruence class.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q <= '0;
                drt_q <= '0;
                lru_q <= 1'b0;
                for (int w = 0; w < WAYS; w++) begin
                    tag_q[w] <= '0;
                    for (int k = 0; k < WORDS; k++) begin
                        dat_q[w][k] <= seed_word(w, s, k);
                    end
                end
            end else begin
                if (here && zfill_en) begin
                    tag_q[zfill_way] <= zfill_tag;
                    vld_q[zfill_way] <= 1'b1;
                    drt_q[zfill_way] <= 1'b1;
                    for (int k = 0; k < WORDS; k++) begin
                        dat_q[zfill_way][k] <= '0;
                    end
                end
                if (here && cinv_en) begin
                    vld_q <= '0;
                    drt_q <= '0;
                end
                if (here && lru_we) begin
                    lru_q <= lru_nxt;
                end
            end
        end

        assign all_tag[s]  = {tag_q[1], tag_q[0]};
        assign all_vld[s]  = vld_q;
        assign all_drt[s]  = drt_q;
        assign all_lru[s]  = lru_q;
        assign all_word[s] = dat_q[rd_way][rd_word];
    end

    // Select the addressed class for the read side.
    always_comb begin
        set_tag   = all_tag[rd_set];
        set_valid = all_vld[rd_set];
        set_dirty = all_drt[rd_set];
        set_lru   = all_lru[rd_set];
        word_data = all_word[rd_set];
    end
endmodule

// File: rtl/cmu_lookup.sv
// Hit check and victim choice for one congruence class.
// Assumes two ways; the replacement bit names the way to evict next.
module cmu_lookup
    import cmu_pkg::*;
#(
    parameter int TAG_W = 23
) (
    input  logic [WAYS-1:0][TAG_W-1:0] set_tag,
    input  logic [WAYS-1:0]            set_valid,
    input  logic                       set_lru,
    input  logic [TAG_W-1:0]           req_tag,
    output logic                       hit,
    output logic                       hit_way,
    output logic                       victim_way
);
    logic [WAYS-1:0] way_hit;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign way_hit[w] = set_valid[w] && (set_tag[w] == req_tag);
    end

    // Reduce per-way matches and choose where a fill would go.
    always_comb begin
        hit     = |way_hit;
        hit_way = way_hit[1];
        if (!set_valid[0]) begin
            victim_way = 1'b0;
        end else if (!set_valid[1]) begin
            victim_way = 1'b1;
        end else begin
            victim_way = set_lru;
        end
    end
endmodule

// File: rtl/cmu_ctrl.sv
// Command decoder: turns an accepted opcode into array updates and
// registers the done strobe, exception flag and result word.
// Assumes the array reads of the addressed class are valid in the same cycle.
module cmu_ctrl
    import cmu_pkg::*;
#(
    parameter int TAG_W = 23,
    parameter int PAD_W = 7
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cmd_valid,
    input  logic [2:0]                 cmd_op,
    input  logic                       attr_cacheable,
    input  logic                       attr_wthru,
    input  logic                       cfg_diag_way,
    input  logic                       cfg_diag_tag,
    input  logic [TAG_W-1:0]           req_tag,
    input  logic                       hit,
    input  logic                       hit_way,
    input  logic                       victim_way,
    input  logic [WAYS-1:0][TAG_W-1:0] set_tag,
    input  logic [WAYS-1:0]            set_valid,
    input  logic [WAYS-1:0]            set_dirty,
    input  logic [DATA_W-1:0]          word_data,
    output logic                       zfill_en,
    output logic                       zfill_way,
    output logic [TAG_W-1:0]           zfill_tag,
    output logic                       cinv_en,
    output logic                       lru_we,
    output logic                       lru_nxt,
    output logic [DATA_W-1:0]          result,
    output logic                       align_exc,
    output logic                       done
);
    maint_op_e         op;
    logic              bad_attr;
    logic              zero_ok;
    logic              touch_hit;
    logic              tgt_way;
    logic [DATA_W-1:0] tag_word;

    // Decode the command into array write controls.
    always_comb begin
        op        = maint_op_e'(cmd_op);
        bad_attr  = !attr_cacheable || attr_wthru;
        zero_ok   = cmd_valid && (op == OP_ZERO) && !bad_attr;
        touch_hit = cmd_valid && ((op == OP_TOUCH_LD) || (op == OP_TOUCH_ST)) && hit;
        tgt_way   = hit ? hit_way : victim_way;
        zfill_en  = zero_ok;
        zfill_way = tgt_way;
        zfill_tag = req_tag;
        cinv_en   = cmd_valid && (op == OP_CINV);
        lru_we    = zero_ok || touch_hit;
        lru_nxt   = zero_ok ? ~tgt_way : ~hit_way;
        tag_word  = {set_tag[cfg_diag_way], {PAD_W{1'b0}},
                     set_valid[cfg_diag_way], set_dirty[cfg_diag_way]};
    end

    // Register the per-command outputs one cycle after acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done      <= 1'b0;
            align_exc <= 1'b0;
            result    <= '0;
        end else begin
            done      <= cmd_valid;
            align_exc <= cmd_valid && (op == OP_ZERO) && bad_attr;
            if (cmd_valid && (op == OP_DREAD)) begin
                result <= cfg_diag_tag ? tag_word : word_data;
            end else begin
                result <= '0;
            end
        end
    end
endmodule

// File: rtl/cache_maint_unit.sv
// Two-way cache maintenance unit: address generation, class lookup,
// command decode and the tag/data array. One command per cycle; results
// appear with done in the following cycle. Assumes 32-bit words.
module cache_maint_unit
    import cmu_pkg::*;
#(
    parameter int SETS       = 16,
    parameter int LINE_WORDS = 8,
    localparam int ADDR_W = DATA_W,
    localparam int WSEL_W = $clog2(LINE_WORDS),
    localparam int IDX_W  = $clog2(SETS),
    localparam int OFF_W  = WSEL_W + 2,
    localparam int TAG_W  = ADDR_W - OFF_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic              base_is_zero,
    input  logic [ADDR_W-1:0] opnd_a,
    input  logic [ADDR_W-1:0] opnd_b,
    input  logic              attr_cacheable,
    input  logic              attr_wthru,
    input  logic              cfg_diag_way,
    input  logic              cfg_diag_tag,
    output logic [DATA_W-1:0] result,
    output logic              align_exc,
    output logic              done
);
    logic [WSEL_W-1:0]          word_sel;
    logic [IDX_W-1:0]           set_sel;
    logic [TAG_W-1:0]           req_tag;
    logic [WAYS-1:0][TAG_W-1:0] set_tag;
    logic [WAYS-1:0]            set_valid;
    logic [WAYS-1:0]            set_dirty;
    logic                       set_lru;
    logic [DATA_W-1:0]          word_data;
    logic                       hit;
    logic                       hit_way;
    logic                       victim_way;
    logic                       zfill_en;
    logic                       zfill_way;
    logic [TAG_W-1:0]           zfill_tag;
    logic                       cinv_en;
    logic                       lru_we;
    logic                       lru_nxt;

    cmu_agen #(.ADDR_W(ADDR_W), .WSEL_W(WSEL_W), .IDX_W(IDX_W)) u_agen (
        .base_zero (base_is_zero),
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .word_sel  (word_sel),
        .set_sel   (set_sel),
        .tag_val   (req_tag)
    );

    cmu_array #(.SETS(SETS), .WORDS(LINE_WORDS), .TAG_W(TAG_W)) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_set    (set_sel),
        .rd_way    (cfg_diag_way),
        .rd_word   (word_sel),
        .zfill_en  (zfill_en),
        .zfill_way (zfill_way),
        .zfill_tag (zfill_tag),
        .cinv_en   (cinv_en),
        .lru_we    (lru_we),
        .lru_nxt   (lru_nxt),
        .set_tag   (set_tag),
        .set_valid (set_valid),
        .set_dirty (set_dirty),
        .set_lru   (set_lru),
        .word_data (word_data)
    );

    cmu_lookup #(.TAG_W(TAG_W)) u_lookup (
        .set_tag    (set_tag),
        .set_valid  (set_valid),
        .set_lru    (set_lru),
        .req_tag    (req_tag),
        .hit        (hit),
        .hit_way    (hit_way),
        .victim_way (victim_way)
    );

    cmu_ctrl #(.TAG_W(TAG_W), .PAD_W(OFF_W + IDX_W - 2)) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .cmd_valid      (cmd_valid),
        .cmd_op         (cmd_op),
        .attr_cacheable (attr_cacheable),
        .attr_wthru     (attr_wthru),
        .cfg_diag_way   (cfg_diag_way),
        .cfg_diag_tag   (cfg_diag_tag),
        .req_tag        (req_tag),
        .hit            (hit),
        .hit_way        (hit_way),
        .victim_way     (victim_way),
        .set_tag        (set_tag),
        .set_valid      (set_valid),
        .set_dirty      (set_dirty),
        .word_data      (word_data),
        .zfill_en       (zfill_en),
        .zfill_way      (zfill_way),
        .zfill_tag      (zfill_tag),
        .cinv_en        (cinv_en),
        .lru_we         (lru_we),
        .lru_nxt        (lru_nxt),
        .result         (result),
        .align_exc      (align_exc),
        .done           (done)
    );
endmodule

// File: rtl/cmu_checks.sv
// Port-level protocol checks for the cache maintenance unit, bound to the top.
module cmu_checks #(
    parameter int PAD_HI = 8
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_valid,
    input logic [2:0]  cmd_op,
    input logic        attr_cacheable,
    input logic        attr_wthru,
    input logic        cfg_diag_tag,
    input logic [31:0] result,
    input logic        align_exc,
    input logic        done
);
    // R9: a command is always answered in the next cycle.
    p_done_follows_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> done);

    // R9: no strobe without a command.
    p_no_stray_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> !done);

    // R9: the exception flag never stands alone.
    p_exc_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        align_exc |-> done);

    // R5: refused zero-line raises the exception.
    p_exc_on_bad_attr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd3 && (!attr_cacheable || attr_wthru)) |=> align_exc);

    // R2: an accepted zero-line and every other opcode leave the flag low.
    p_no_exc_otherwise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !(cmd_op == 3'd3 && (!attr_cacheable || attr_wthru))) |=> !align_exc);

    // R9: non-diagnostic commands return zero.
    p_result_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op != 3'd5) |=> (result == 32'd0));

    // R7: tag-mode result has a zero pad between tag and state bits.
    p_tag_pad_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd5 && cfg_diag_tag) |=> (result[PAD_HI:2] == '0));
endmodule

bind cache_maint_unit cmu_checks #(.PAD_HI(OFF_W + IDX_W - 1)) u_checks (
    .clk            (clk),
    .rst_n          (rst_n),
    .cmd_valid      (cmd_valid),
    .cmd_op         (cmd_op),
    .attr_cacheable (attr_cacheable),
    .attr_wthru     (attr_wthru),
    .cfg_diag_tag   (cfg_diag_tag),
    .result         (result),
    .align_exc      (align_exc),
    .done           (done)
);

// File: tb/cache_maint_unit_test.sv
`timescale 1ns/1ps
module cache_maint_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = 3'd0;
    logic        base_is_zero = 1'b0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic        attr_cacheable = 1'b1;
    logic        attr_wthru = 1'b0;
    logic        cfg_diag_way = 1'b0;
    logic        cfg_diag_tag = 1'b0;
    logic [31:0] result;
    logic        align_exc;
    logic        done;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    // Bench model of the array, built from the requirements.
    logic [22:0] m_tag  [16][2];
    logic        m_v    [16][2];
    logic        m_d    [16][2];
    logic        m_lru  [16];
    logic [31:0] m_data [16][2][8];

    always #2 clk = ~clk;

    cache_maint_unit uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .base_is_zero(base_is_zero), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .attr_cacheable(attr_cacheable), .attr_wthru(attr_wthru),
        .cfg_diag_way(cfg_diag_way), .cfg_diag_tag(cfg_diag_tag),
        .result(result), .align_exc(align_exc), .done(done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    function automatic logic [31:0] mk_ea(input logic [22:0] t, input int s, input int k);
        return {t, 4'(s), 3'(k), 2'b00};
    endfunction

    // R10: model reset content.
    task automatic model_reset();
        for (int s = 0; s < 16; s++) begin
            m_lru[s] = 1'b0;
            for (int w = 0; w < 2; w++) begin
                m_tag[s][w] = '0; m_v[s][w] = 1'b0; m_d[s][w] = 1'b0;
                for (int k = 0; k < 8; k++)
                    m_data[s][w][k] = 32'hD000_0000 | (32'(w) << 12) | (32'(s) << 4) | 32'(k);
            end
        end
    endtask

    // Issue one command, update the model and compare the done-cycle outputs.
    task automatic do_cmd(input logic [2:0] op, input bit selz, input logic [31:0] a,
                          input logic [31:0] b, input bit cach, input bit wt,
                          input bit way, input bit tsel, input string req);
        logic [31:0] ea, exp_res;
        bit          exp_exc, hit, hw, tw;
        int          s, k;
        logic [22:0] t;
        ea = (selz ? 32'd0 : a) + b;
        k = int'(ea[4:2]); s = int'(ea[8:5]); t = ea[31:9];
        hit = 1'b0; hw = 1'b0;
        for (int w = 0; w < 2; w++)
            if (m_v[s][w] && m_tag[s][w] == t) begin hit = 1'b1; hw = w[0]; end
        exp_res = '0; exp_exc = 1'b0;
        case (op)
            3'd1, 3'd2: if (hit) m_lru[s] = ~hw;
            3'd3: begin
                if (!cach || wt) exp_exc = 1'b1;
                else begin
                    tw = hit ? hw : (!m_v[s][0] ? 1'b0 : (!m_v[s][1] ? 1'b1 : m_lru[s]));
                    m_tag[s][tw] = t; m_v[s][tw] = 1'b1; m_d[s][tw] = 1'b1;
                    for (int j = 0; j < 8; j++) m_data[s][tw][j] = '0;
                    m_lru[s] = ~tw;
                end
            end
            3'd4: for (int w = 0; w < 2; w++) begin m_v[s][w] = 1'b0; m_d[s][w] = 1'b0; end
            3'd5: exp_res = tsel ? {m_tag[s][way], 7'd0, m_v[s][way], m_d[s][way]}
                                 : m_data[s][way][k];
            default: ;
        endcase
        cmd_valid = 1'b1; cmd_op = op; base_is_zero = selz; opnd_a = a; opnd_b = b;
        attr_cacheable = cach; attr_wthru = wt; cfg_diag_way = way; cfg_diag_tag = tsel;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(done === 1'b1, "R9", "done strobe", 32'(done), 32'd1);
        chk(align_exc === exp_exc, req, "align_exc", 32'(align_exc), 32'(exp_exc));
        chk(result === exp_res, req, "result", result, exp_res);
    endtask

    task automatic idle_check();
        @(negedge clk);
        chk(done === 1'b0, "R9", "done after idle", 32'(done), 32'd0);
    endtask

    task automatic read_tags(input string req);
        for (int s = 0; s < 16; s++)
            for (int w = 0; w < 2; w++)
                do_cmd(3'd5, 1'b1, 32'hFFFF_FFFF, mk_ea(23'h7, s, 0), 1'b1, 1'b0, w[0], 1'b1, req);
    endtask

    task automatic read_data(input string req);
        for (int s = 0; s < 16; s++)
            for (int w = 0; w < 2; w++)
                for (int k = 0; k < 8; k++)
                    do_cmd(3'd5, 1'b0, 32'd0, mk_ea(23'h0, s, k), 1'b1, 1'b0, w[0], 1'b0, req);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(done === 1'b0, "R10", "done after reset", 32'(done), 32'd0);
        chk(align_exc === 1'b0, "R10", "exc after reset", 32'(align_exc), 32'd0);
        chk(result === 32'd0, "R10", "result after reset", result, 32'd0);

        // R10 / R7: reset tags and seeded data, read by way and word.
        read_tags("R10");
        read_data("R7");

        // R6: invalidate an untouched class keeps data and replacement bit.
        do_cmd(3'd4, 1'b0, 32'd0, mk_ea(23'h5, 0, 0), 1'b0, 1'b1, 1'b0, 1'b0, "R6");
        for (int k = 0; k < 8; k++)
            do_cmd(3'd5, 1'b0, 32'd0, mk_ea(23'h0, 0, k), 1'b1, 1'b0, 1'b1, 1'b0, "R6");

        // R5: refused zero-line leaves everything unchanged.
        do_cmd(3'd3, 1'b0, 32'd0, mk_ea(23'h11, 3, 2), 1'b0, 1'b0, 1'b0, 1'b0, "R5");
        do_cmd(3'd3, 1'b0, 32'd0, mk_ea(23'h11, 3, 2), 1'b1, 1'b1, 1'b0, 1'b0, "R5");
        do_cmd(3'd3, 1'b0, 32'd0, mk_ea(23'h11, 3, 2), 1'b0, 1'b1, 1'b0, 1'b0, "R5");
        idle_check();
        for (int w = 0; w < 2; w++) begin
            do_cmd(3'd5, 1'b0, 32'd0, mk_ea(23'h0, 3, 2), 1'b1, 1'b0, w[0], 1'b1, "R5");
            do_cmd(3'd5, 1'b0, 32'd0, mk_ea(23'h0, 3, 2), 1'b1, 1'b0, w[0], 1'b0, "R5");
        end

        // R1 / R3: fill way 0 then way 1 in every class, operands split apart.
        for (int s = 0; s < 16; s++)
            do_cmd(3'd3, 1'b0, 32'h0000_0040 * 32'(s), mk_ea(23'h100 + 23'(s), s, 0) - 32'h0000_0040 * 32'(s),
                   1'b1, 1'b0, 1'b0, 1'b0, "R1");
        for (int s = 0; s < 16; s++)
            do_cmd(3'd3, 1'b1, 32'hDEAD_BEEF, mk_ea(23'h200, s, 5), 1'b1, 1'b0, 1'b0, 1'b0, "R3");
        read_tags("R3");

        // R4: third tag evicts way 0; touches then steer the next victim.
        for (int s = 0; s < 16; s++)
            do_cmd(3'd3, 1'b0, 32'd4, mk_ea(23'h300, s, 1) - 32'd4, 1'b1, 1'b0, 1'b0, 1'b0, "R4");
        for (int s = 0; s < 16; s++) begin
            // R8: opcode 1 on even, 2 on odd classes; half hit way 1, half miss.
            if (s < 8)
                do_cmd((s % 2 == 0) ? 3'd1 : 3'd2, 1'b0, 32'd0, mk_ea(23'h200, s, 3), 1'b1, 1'b0, 1'b0, 1'b0, "R8");
            else
                do_cmd((s % 2 == 0) ? 3'd1 : 3'd2, 1'b0, 32'd0, mk_ea(23'h7AB, s, 3), 1'b1, 1'b0, 1'b0, 1'b0, "R8");
        end
        for (int s = 0; s < 16; s++)
            do_cmd(3'd3, 1'b0, 32'd0, mk_ea(23'h400, s, 7), 1'b1, 1'b0, 1'b0, 1'b0, "R4");
        read_tags("R4");

        // R2: hit on an existing line keeps its way, other way untouched.
        do_cmd(3'd3, 1'b0, 32'd0, mk_ea(23'h400, 9, 0), 1'b1, 1'b0, 1'b0, 1'b0, "R2");
        read_tags("R2");
        read_data("R2");

        // R6: invalidate even classes; tags stay, state clears; refill goes to way 0.
        for (int s = 0; s < 16; s += 2)
            do_cmd(3'd4, 1'b0, 32'd0, mk_ea(23'h1, s, 0), 1'b1, 1'b0, 1'b0, 1'b0, "R6");
        read_tags("R6");
        do_cmd(3'd3, 1'b0, 32'd0, mk_ea(23'h555, 4, 0), 1'b1, 1'b0, 1'b0, 1'b0, "R3");
        do_cmd(3'd5, 1'b0, 32'd0, mk_ea(23'h0, 4, 0), 1'b1, 1'b0, 1'b0, 1'b1, "R3");
        do_cmd(3'd5, 1'b0, 32'd0, mk_ea(23'h0, 4, 0), 1'b1, 1'b0, 1'b1, 1'b1, "R6");

        // R9: unused opcodes do nothing and return zero.
        do_cmd(3'd0, 1'b0, 32'd0, mk_ea(23'h400, 5, 0), 1'b1, 1'b0, 1'b0, 1'b1, "R9");
        do_cmd(3'd6, 1'b0, 32'd0, mk_ea(23'h999, 5, 0), 1'b1, 1'b0, 1'b0, 1'b1, "R9");
        do_cmd(3'd7, 1'b0, 32'd0, mk_ea(23'h999, 5, 0), 1'b1, 1'b0, 1'b0, 1'b1, "R9");
        idle_check();
        read_tags("R9");
        idle_check();
        summary();
    end
endmodule